// File: doc/BRIEF.md
# Dual-Edge Cascadable Decimal Counter

This block is a chain of decimal counter stages. Each stage holds one binary-coded-decimal digit from 0 to 9. The digit advances on both the rising and the falling edge of the shared clock, but only while that stage's count enable is high. The first stage is enabled by the block's count-enable input. Every later stage is enabled by the carry-out of the stage before it, so the chain counts as a multi-digit decimal number, with one count for each enabled clock edge.

Each stage reports two flags. The first is a terminal-count flag, high when the stage shows 9. The second is a carry-out, which is the terminal-count flag gated by that stage's own enable. Both flags are combinational, so a carry reaches the next stage in the same clock phase.

An asynchronous, active-high clear overrides everything else and zeroes the whole chain. The block is held in clear at power-up, which gives the cleared start-up state. Digit codes above 9 cannot occur in normal counting. If one does appear, the stage returns to 0 on its next enabled edge.

The block carries no data stream. All of its pins are plain control and status signals, so it has no valid/ready handshake and no back-pressure.

Top module: `dd_bcd_chain`

## Requirements
- R1: While `clr` is high, every digit of `count`, every bit of `tc` and every bit of `ceo` is 0, whatever `clk` and `cnt_en` do. Clearing takes effect without a clock edge. After `clr` falls, the count starts from 0.
- R2: On a rising `clk` edge at which a stage's enable is high, that stage's digit goes from d to d+1 (for d from 0 to 8).
- R3: On a falling `clk` edge at which a stage's enable is high, that stage's digit goes from d to d+1 (for d from 0 to 8).
- R4: A clock edge at which a stage's enable is low leaves that stage's digit unchanged.
- R5: A stage showing 9 goes to 0 on its next enabled edge.
- R6: `tc[k]` is high exactly when digit k equals 4'b1001, with no register delay. It is low for every other code, including 1010 to 1111.
- R7: `ceo[k]` equals `tc[k]` AND stage k's enable, with no register delay.
- R8: Stage 0 is enabled by `cnt_en`, and stage k (k ≥ 1) is enabled by `ceo[k-1]`. Digit k appears on `count[4k+3:4k]`. The chain therefore counts modulo 10^DIGITS, one count per enabled edge of either polarity.
- R9: A stage holding an illegal code (1010 to 1111) shows 0000 after its first enabled edge, with no carry out of that stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock; both edges are active |
| clr | input | 1 | Asynchronous clear, active high, highest priority |
| cnt_en | input | 1 | Count enable for stage 0 |
| count | output | 4*DIGITS | Packed BCD digits, with stage 0 in the lowest nibble |
| tc | output | DIGITS | Per-stage terminal count (digit is 9) |
| ceo | output | DIGITS | Per-stage carry-out (terminal count AND stage enable) |

## Verification
A long run with the enable held high walks every stage through all ten codes and wraps the whole chain from 999 to 000. This exercises the carry path and the terminal-count and carry-out flags at each digit boundary.

An enable that alternates on every edge lets only the rising edges count, or only the falling edges, depending on the phase. Both phases are run, so a stage that counts on only one polarity is caught. Runs with the enable held low, and with an irregular enable pattern, separate true holding from counting.

A clear raised between edges during a nonzero count checks that clearing needs no clock edge. Codes 1011 and 1111 are placed into the first stage while it is held in clear, and the first enabled edge afterwards must return that stage to zero without carrying into the next stage.

// File: rtl/dd_bcd_pkg.sv
`timescale 1ns/1ps
package dd_bcd_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t DIGIT_TOP = digit_t'(9);

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  function automatic logic is_legal(input digit_t d);
    return d <= DIGIT_TOP;
  endfunction
endpackage

// File: rtl/dd_bcd_step.sv
`timescale 1ns/1ps
module dd_bcd_step
  import dd_bcd_pkg::*;
(
  input  digit_t cur,
  output digit_t nxt,
  output logic   at_top,
  output logic   bad_code
);
  // The top code and every illegal code fold to zero on the next count.
  always_comb begin
    at_top   = (cur == DIGIT_TOP);
    bad_code = !is_legal(cur);
    if (at_top || bad_code) nxt = '0;
    else                    nxt = digit_t'(cur + digit_t'(1));
  end
endmodule

// File: rtl/dd_bcd_half_reg.sv
`timescale 1ns/1ps
module dd_bcd_half_reg
  import dd_bcd_pkg::*;
#(
  parameter edge_sel_e EDGE = EDGE_RISE
) (
  input  logic   clk,
  input  logic   clr,
  input  logic   en,
  input  digit_t d,
  output digit_t half_q
);
  // One half of the split state; the parameter picks which clock edge loads it.
  generate
    if (EDGE == EDGE_FALL) begin : g_fall
      always_ff @(negedge clk or posedge clr) begin
        if (clr)     half_q <= '0;
        else if (en) half_q <= d;
      end
    end else begin : g_rise
      always_ff @(posedge clk or posedge clr) begin
        if (clr)     half_q <= '0;
        else if (en) half_q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/dd_bcd_stage.sv
`timescale 1ns/1ps
module dd_bcd_stage
  import dd_bcd_pkg::*;
(
  input  logic   clk,
  input  logic   clr,
  input  logic   ce,
  output digit_t digit,
  output logic   tc,
  output logic   ceo
);
  digit_t rise_half, fall_half;
  digit_t nxt_digit, rise_d, fall_d;
  logic   at_top, bad_code;

  dd_bcd_step u_step (
    .cur     (digit),
    .nxt     (nxt_digit),
    .at_top  (at_top),
    .bad_code(bad_code)
  );

  // Visible digit is the XOR of both halves. Each half loads the value that
  // makes the XOR equal the next digit, given the other half's present value.
  assign digit  = rise_half ^ fall_half;
  assign rise_d = nxt_digit ^ fall_half;
  assign fall_d = nxt_digit ^ rise_half;

  dd_bcd_half_reg #(.EDGE(EDGE_RISE)) u_rise (
    .clk   (clk),
    .clr   (clr),
    .en    (ce),
    .d     (rise_d),
    .half_q(rise_half)
  );

  dd_bcd_half_reg #(.EDGE(EDGE_FALL)) u_fall (
    .clk   (clk),
    .clr   (clr),
    .en    (ce),
    .d     (fall_d),
    .half_q(fall_half)
  );

  assign tc  = at_top;
  assign ceo = at_top & ce;

  // ---------------- checks kept beside the stage logic ----------------
  // Shadow of the pre-edge digit and enable, taken at each edge polarity and
  // compared at the opposite edge against the digit that edge produced.
  digit_t pre_r_q, pre_f_q;
  logic   pre_r_en, pre_f_en, pre_r_vld, pre_f_vld;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      pre_r_q   <= '0;
      pre_r_en  <= 1'b0;
      pre_r_vld <= 1'b0;
    end else begin
      pre_r_q   <= digit;
      pre_r_en  <= ce;
      pre_r_vld <= 1'b1;
    end
  end

  always_ff @(negedge clk or posedge clr) begin
    if (clr) begin
      pre_f_q   <= '0;
      pre_f_en  <= 1'b0;
      pre_f_vld <= 1'b0;
    end else begin
      pre_f_q   <= digit;
      pre_f_en  <= ce;
      pre_f_vld <= 1'b1;
    end
  end

  // Result of the rising edge, seen at the following falling edge.
  always @(negedge clk) begin
    if (!clr && pre_r_vld) begin
      if (!pre_r_en)
        a_r4_hold_rise: assert (digit == pre_r_q);
      else if (pre_r_q > DIGIT_TOP)
        a_r9_recover_rise: assert (digit == '0);
      else if (pre_r_q == DIGIT_TOP)
        a_r5_wrap_rise: assert (digit == '0);
      else
        a_r2_step_rise: assert (digit == digit_t'(pre_r_q + digit_t'(1)));
    end
  end

  // Result of the falling edge, seen at the following rising edge.
  always @(posedge clk) begin
    if (!clr && pre_f_vld) begin
      if (!pre_f_en)
        a_r4_hold_fall: assert (digit == pre_f_q);
      else if (pre_f_q > DIGIT_TOP)
        a_r9_recover_fall: assert (digit == '0);
      else if (pre_f_q == DIGIT_TOP)
        a_r5_wrap_fall: assert (digit == '0);
      else
        a_r3_step_fall: assert (digit == digit_t'(pre_f_q + digit_t'(1)));
    end
  end

  a_r1_cleared: assert property (@(posedge clk) clr |-> (digit == '0 && !tc && !ceo));
  a_r6_no_tc_on_bad: assert property (@(posedge clk) disable iff (clr) bad_code |-> !tc);
  a_r7_ceo_needs_ce: assert property (@(posedge clk) disable iff (clr) ceo |-> (ce && digit == DIGIT_TOP));
endmodule

// File: rtl/dd_bcd_chain.sv
`timescale 1ns/1ps
module dd_bcd_chain
  import dd_bcd_pkg::*;
#(
  parameter int unsigned DIGITS = 3
) (
  input  logic                      clk,
  input  logic                      clr,
  input  logic                      cnt_en,
  output logic [DIGITS*DIGIT_W-1:0] count,
  output logic [DIGITS-1:0]         tc,
  output logic [DIGITS-1:0]         ceo
);
  logic [DIGITS-1:0] stage_ce;
  digit_t            stage_digit [DIGITS];

  genvar k;
  generate
    for (k = 0; k < DIGITS; k++) begin : g_stage
      if (k == 0) begin : g_head
        assign stage_ce[k] = cnt_en;
      end else begin : g_link
        assign stage_ce[k] = ceo[k-1];

        // R8: a stage only advances while its neighbour below sits at 9 and is enabled.
        a_r8_carry_in: assert property (@(posedge clk) disable iff (clr)
          stage_ce[k] |-> (stage_digit[k-1] == DIGIT_TOP && stage_ce[k-1]));
      end

      dd_bcd_stage u_stage (
        .clk  (clk),
        .clr  (clr),
        .ce   (stage_ce[k]),
        .digit(stage_digit[k]),
        .tc   (tc[k]),
        .ceo  (ceo[k])
      );

      assign count[k*DIGIT_W +: DIGIT_W] = stage_digit[k];
    end
  endgenerate
endmodule

// File: tb/dd_bcd_chain_test.sv
`timescale 1ns/1ps
module dd_bcd_chain_test;
  localparam int D   = 3;
  localparam int MOD = 1000;

  logic clk = 1'b0;
  logic clr = 1'b0;
  logic cnt_en = 1'b0;
  logic [D*4-1:0] count;
  logic [D-1:0]   tc;
  logic [D-1:0]   ceo;

  int n_chk  = 0;
  int n_fail = 0;
  int model  = 0;
  bit done   = 1'b0;
  int q_val[$];
  bit q_en[$];

  dd_bcd_chain #(.DIGITS(D)) uut (
    .clk   (clk),
    .clr   (clr),
    .cnt_en(cnt_en),
    .count (count),
    .tc    (tc),
    .ceo   (ceo)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [D*4-1:0] to_bcd(input int v);
    logic [D*4-1:0] r;
    int t;
    t = v;
    for (int i = 0; i < D; i++) begin
      r[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic [D-1:0] tc_of(input int v);
    logic [D-1:0] r;
    int t;
    t = v;
    for (int i = 0; i < D; i++) begin
      r[i] = ((t % 10) == 9);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic [D-1:0] ceo_of(input int v, input bit e);
    logic [D-1:0] r;
    logic [D-1:0] t9;
    logic c;
    t9 = tc_of(v);
    c  = e;
    for (int i = 0; i < D; i++) begin
      c    = c & t9[i];
      r[i] = c;
    end
    return r;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  // Driver: sets the enable for the coming edge and queues the expected result.
  task automatic step(input bit e);
    @(clk);
    #2;
    cnt_en = e;
    if (e) model = (model + 1) % MOD;
    q_val.push_back(model);
    q_en.push_back(e);
  endtask

  task automatic drain();
    while (q_val.size() > 0) #1;
    #2;
  endtask

  // Monitor: one expected item per clock edge, compared just after that edge.
  initial begin
    forever begin
      @(clk);
      #1;
      if (q_val.size() > 0) begin
        int    v;
        bit    e;
        string tag;
        v = q_val.pop_front();
        e = q_en.pop_front();
        tag = !e ? "R4 hold" : (clk ? "R2 rise" : "R3 fall");
        chk({tag, " R5 R8 count"}, int'(count), int'(to_bcd(v)));
        chk({tag, " R6 tc"}, int'(tc), int'(tc_of(v)));
        chk({tag, " R7 ceo"}, int'(ceo), int'(ceo_of(v, e)));
      end
    end
  end

  // R9: place an illegal code in stage 0 while clear is held, then count once.
  task automatic inject(input logic [3:0] code);
    @(clk);
    #2;
    cnt_en = 1'b0;
    clr    = 1'b1;
    #1;
    force uut.g_stage[0].u_stage.u_rise.half_q = code;
    force uut.g_stage[0].u_stage.u_fall.half_q = 4'h0;
    #1;
    release uut.g_stage[0].u_stage.u_rise.half_q;
    release uut.g_stage[0].u_stage.u_fall.half_q;
    #1;
    clr = 1'b0;
    #1;
    chk("R9 illegal code visible", int'(count), int'({8'h00, code}));
    chk("R9 R6 tc low on illegal code", int'(tc), 0);
    chk("R9 R7 ceo low on illegal code", int'(ceo), 0);
    model = 0;
    @(clk);
    #2;
    cnt_en = 1'b1;
    q_val.push_back(0);
    q_en.push_back(1'b1);
    step(1'b0);
    drain();
    chk("R9 recovered to zero without carry", int'(count), 0);
  endtask

  initial begin
    #1;
    clr    = 1'b1;
    cnt_en = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 count under clear", int'(count), 0);
    chk("R1 tc under clear", int'(tc), 0);
    chk("R1 ceo under clear", int'(ceo), 0);
    cnt_en = 1'b0;
    #2;
    clr = 1'b0;
    #1;
    chk("R1 count after clear release", int'(count), 0);
    model = 0;

    // Continuous enable: full wrap 999 -> 000.
    repeat (1005) step(1'b1);
    step(1'b0);
    // Alternating enable, one phase: only one edge polarity counts.
    repeat (40) begin
      step(1'b1);
      step(1'b0);
    end
    step(1'b0);
    // Alternating enable, other phase.
    repeat (40) begin
      step(1'b1);
      step(1'b0);
    end
    // Enable held low.
    repeat (12) step(1'b0);
    // Irregular enable.
    for (int i = 0; i < 90; i++) step(i % 3 != 0);
    step(1'b0);
    drain();

    // Asynchronous clear in the middle of a nonzero count.
    chk("R8 count before clear", int'(count), int'(to_bcd(model)));
    clr = 1'b1;
    #1;
    chk("R1 async clear count", int'(count), 0);
    chk("R1 async clear tc", int'(tc), 0);
    cnt_en = 1'b1;
    repeat (2) @(clk);
    #3;
    chk("R1 clear held with enable high", int'(count), 0);
    chk("R1 ceo under clear with enable", int'(ceo), 0);
    cnt_en = 1'b0;
    clr = 1'b0;
    #1;
    chk("R1 count after second release", int'(count), 0);
    model = 0;

    inject(4'hB);
    inject(4'hF);

    repeat (12) step(1'b1);
    step(1'b0);
    drain();
    chk("R8 final count", int'(count), int'(to_bcd(model)));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule